// File: doc/BRIEF.md
# CRC-3 Frame Generator and Checker

This block computes a 3-bit cyclic redundancy code over a 32-bit serial-bus frame. The same datapath serves in two modes. In generate mode the low three bits of the incoming word are treated as zero, the code is computed over the result, and it is placed into those three bits to form an outgoing frame. In check mode the whole word is run through the same computation, code field included, and the remainder that is left decides whether the frame is intact.

The computation is the bit-serial shift register algorithm unrolled into one combinational chain, with one cell for each data bit. The register starts from a nonzero seed. Each step samples the top bit, shifts left, takes in the next data bit and XORs in the feedback polynomial when the sampled bit was one. A parameter selects whether the results leave through a reset output register or go straight to the ports. Both builds give the same values, and the registered build gives them one cycle later.

Top module: `crc3_frame_unit`

## Requirements
- R1: The remainder register starts at 3'b101. An all-zero word in check mode therefore yields remainder 3'b011, and the check-mode word 32'h0000_0003 yields remainder 3'b000 with out_ok high.
- R2: With in_mode = 0 (generate), out_crc is the code computed over in_word with bits [2:0] forced to zero, processing bit 31 first. The feedback is 3'b011, which is the constant 0x0B kept to three bits. out_frame is {in_word[31:3], out_crc}.
- R3: With in_mode = 1 (check), out_crc is the remainder over all 32 bits of in_word, out_frame equals in_word, and out_ok is 1 exactly when that remainder is 3'b000.
- R4: In generate mode, in_word[2:0] has no effect: words that differ only in those bits give the same out_crc and out_frame.
- R5: A frame produced in generate mode, when presented in check mode, gives remainder 3'b000 and out_ok = 1.
- R6: Flipping any single one of the 32 bits of a generated frame gives out_ok = 0 in check mode.
- R7: With OUT_REG = 1, the outputs show the result for the inputs of the previous clock edge, and while rst_n is low they are all zero. With OUT_REG = 0, the outputs follow the inputs in the same cycle. Both builds give identical values.
- R8: out_ok is 0 whenever the result comes from generate mode.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, clears the output register |
| in_word | input | 32 | Word to encode (generate) or frame to verify (check) |
| in_mode | input | 1 | 0 = generate, 1 = check |
| out_frame | output | 32 | Generated frame, or the checked word unchanged |
| out_crc | output | 3 | Generated code, or the check remainder |
| out_ok | output | 1 | High when a checked frame leaves a zero remainder |

## Verification
The bench builds two copies with default widths, seed and polynomial. One copy uses OUT_REG = 1 and the other uses OUT_REG = 0. Both copies are driven with the same words, and every result is compared between them, so the combinational build and the registered build are shown to agree value for value and the registered build is shown to be one cycle late. Since both copies share the 32-bit, 3-bit-code geometry, the bench can walk every single-bit error position of a frame. It can also confirm the known remainder that the seed leaves on an all-zero word.

// File: rtl/crc3_pkg.sv
package crc3_pkg;
   typedef enum logic {
      MODE_GEN = 1'b0,
      MODE_CHK = 1'b1
   } crc_mode_e;

   localparam int DEF_DATA_W = 32;
   localparam int DEF_CRC_W  = 3;
   localparam int DEF_SEED   = 5;
   localparam int DEF_POLY   = 11;
endpackage

// File: rtl/crc_bit_cell.sv
module crc_bit_cell #(
   parameter int               CRC_W     = 3,
   parameter logic [CRC_W-1:0] POLY_BITS = 3'b011
) (
   input  logic [CRC_W-1:0] st_in,
   input  logic             din,
   output logic [CRC_W-1:0] st_out
);
   logic             fb;
   logic [CRC_W-1:0] shifted;

   always_comb begin
      fb      = st_in[CRC_W-1];
      shifted = {st_in[CRC_W-2:0], din};
      st_out  = fb ? (shifted ^ POLY_BITS) : shifted;
   end
endmodule

// File: rtl/crc_serial_chain.sv
module crc_serial_chain #(
   parameter int               DATA_W    = 32,
   parameter int               CRC_W     = 3,
   parameter int               SEED      = 5,
   parameter logic [CRC_W-1:0] POLY_BITS = 3'b011
) (
   input  logic [DATA_W-1:0] word,
   output logic [CRC_W-1:0]  rem
);
   localparam logic [CRC_W-1:0] SEED_BITS = CRC_W'(SEED);

   logic [DATA_W:0][CRC_W-1:0] st;

   assign st[0] = SEED_BITS;

   for (genvar i = 0; i < DATA_W; i++) begin : g_step
      crc_bit_cell #(
         .CRC_W     (CRC_W),
         .POLY_BITS (POLY_BITS)
      ) u_cell (
         .st_in  (st[i]),
         .din    (word[DATA_W-1-i]),
         .st_out (st[i+1])
      );
   end

   assign rem = st[DATA_W];
endmodule

// File: rtl/crc_frame_shaper.sv
module crc_frame_shaper
   import crc3_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CRC_W  = 3
) (
   input  logic              mode,
   input  logic [DATA_W-1:0] word,
   input  logic [CRC_W-1:0]  rem,
   output logic [DATA_W-1:0] msg,
   output logic [DATA_W-1:0] frame,
   output logic [CRC_W-1:0]  crc,
   output logic              ok
);
   logic is_chk;

   always_comb begin
      is_chk = (mode == MODE_CHK);
      msg    = is_chk ? word : {word[DATA_W-1:CRC_W], {CRC_W{1'b0}}};
      frame  = is_chk ? word : {word[DATA_W-1:CRC_W], rem};
      crc    = rem;
      ok     = is_chk && (rem == '0);
   end
endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage #(
   parameter int W       = 36,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_comb
      assign q = d;
   end
endmodule

// File: rtl/crc3_frame_unit.sv
module crc3_frame_unit
   import crc3_pkg::*;
#(
   parameter int DATA_W  = DEF_DATA_W,
   parameter int CRC_W   = DEF_CRC_W,
   parameter int SEED    = DEF_SEED,
   parameter int POLY    = DEF_POLY,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_word,
   input  logic              in_mode,
   output logic [DATA_W-1:0] out_frame,
   output logic [CRC_W-1:0]  out_crc,
   output logic              out_ok
);
   localparam logic [CRC_W-1:0] POLY_BITS = CRC_W'(POLY);
   localparam int               RES_W     = DATA_W + CRC_W + 1;

   if (CRC_W < 2) begin : g_bad_crc_w
      $error("CRC_W must be at least 2");
   end
   if (DATA_W <= CRC_W) begin : g_bad_data_w
      $error("DATA_W must exceed CRC_W");
   end
   if (POLY_BITS[0] != 1'b1) begin : g_bad_poly
      $error("polynomial needs a unit term for single-bit detection");
   end
   if (SEED < 0 || SEED >= (1 << CRC_W)) begin : g_bad_seed
      $error("SEED does not fit in CRC_W bits");
   end

   logic [DATA_W-1:0] msg;
   logic [DATA_W-1:0] frame_c;
   logic [CRC_W-1:0]  rem;
   logic [CRC_W-1:0]  crc_c;
   logic              ok_c;
   logic [RES_W-1:0]  res_d;
   logic [RES_W-1:0]  res_q;

   crc_frame_shaper #(
      .DATA_W (DATA_W),
      .CRC_W  (CRC_W)
   ) u_shaper (
      .mode  (in_mode),
      .word  (in_word),
      .rem   (rem),
      .msg   (msg),
      .frame (frame_c),
      .crc   (crc_c),
      .ok    (ok_c)
   );

   crc_serial_chain #(
      .DATA_W    (DATA_W),
      .CRC_W     (CRC_W),
      .SEED      (SEED),
      .POLY_BITS (POLY_BITS)
   ) u_chain (
      .word (msg),
      .rem  (rem)
   );

   assign res_d = {frame_c, crc_c, ok_c};

   crc_out_stage #(
      .W       (RES_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (res_d),
      .q     (res_q)
   );

   assign out_frame = res_q[RES_W-1 -: DATA_W];
   assign out_crc   = res_q[CRC_W:1];
   assign out_ok    = res_q[0];

   // R2: the generated frame carries the chain's code in its low field
   p_gen_low_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mode == MODE_GEN) |-> (frame_c[CRC_W-1:0] == rem));

   // R2: the upper part of a generated frame is the input's upper part
   p_gen_upper_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mode == MODE_GEN) |-> (frame_c[DATA_W-1:CRC_W] == in_word[DATA_W-1:CRC_W]));

   // R3: a checked word passes through untouched
   p_chk_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mode == MODE_CHK) |-> (frame_c == in_word));

   // R4: generate mode feeds the chain with a cleared code field
   p_gen_field_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mode == MODE_GEN) |-> (msg[CRC_W-1:0] == '0));

   if (OUT_REG) begin : g_chk_reg
      // R7, R8: a registered pass flag comes from a check-mode input one edge back
      p_ok_lags_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
         out_ok |-> ($past(in_mode) == MODE_CHK));
   end else begin : g_chk_comb
      // R8: a combinational pass flag only appears in check mode
      p_ok_needs_chk_r8: assert property (@(posedge clk) disable iff (!rst_n)
         out_ok |-> (in_mode == MODE_CHK));
   end
endmodule

// File: tb/crc3_frame_unit_test.sv
`timescale 1ns/1ps
module crc3_frame_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_mode = 1'b0;

   logic [31:0] r_frame, c_frame;
   logic [2:0]  r_crc, c_crc;
   logic        r_ok, c_ok;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   crc3_frame_unit #(.OUT_REG(1'b1)) uut (
      .clk (clk), .rst_n (rst_n), .in_word (in_word), .in_mode (in_mode),
      .out_frame (r_frame), .out_crc (r_crc), .out_ok (r_ok)
   );

   crc3_frame_unit #(.OUT_REG(1'b0)) uut_comb (
      .clk (clk), .rst_n (rst_n), .in_word (in_word), .in_mode (in_mode),
      .out_frame (c_frame), .out_crc (c_crc), .out_ok (c_ok)
   );

   // values captured by apply()
   logic [31:0] s_frame;
   logic [2:0]  s_crc;
   logic        s_ok;

   function automatic logic [2:0] ref_crc(input logic [31:0] w);
      int r = 5;
      for (int i = 31; i >= 0; i--) begin
         int top = r & 4;
         r = (r << 1) | ((w >> i) & 1);
         if (top != 0) r = r ^ 'h0B;
         r = r & 7;
      end
      return 3'(r);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive at negedge, read the combinational copy, then the registered one
   task automatic apply(input logic [31:0] w, input logic m);
      logic [31:0] cf;
      logic [2:0]  cc;
      logic        co;
      @(negedge clk);
      in_word = w;
      in_mode = m;
      #1;
      cf = c_frame; cc = c_crc; co = c_ok;
      @(negedge clk);
      s_frame = r_frame; s_crc = r_crc; s_ok = r_ok;
      chk("R7", "frame comb vs reg", {31'b0, (cf === s_frame)}, 32'd1);
      chk("R7", "crc comb vs reg",   {29'b0, cc}, {29'b0, s_crc});
      chk("R7", "ok comb vs reg",    {31'b0, co}, {31'b0, s_ok});
   endtask

   task automatic t_reset;
      #1;
      chk("R7", "reset frame", r_frame, 32'h0);
      chk("R7", "reset crc",   {29'b0, r_crc}, 32'h0);
      chk("R7", "reset ok",    {31'b0, r_ok}, 32'h0);
   endtask

   task automatic t_seed;
      apply(32'h0, 1'b1);
      chk("R1", "zero word remainder", {29'b0, s_crc}, 32'd3);
      chk("R1", "zero word ok", {31'b0, s_ok}, 32'd0);
      apply(32'h3, 1'b1);
      chk("R1", "seed frame remainder", {29'b0, s_crc}, 32'd0);
      chk("R1", "seed frame ok", {31'b0, s_ok}, 32'd1);
   endtask

   task automatic t_generate;
      logic [31:0] words [6] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_A5A0,
                                  32'h1234_5678, 32'h8000_0000, 32'h0000_0008};
      foreach (words[k]) begin
         logic [2:0] e = ref_crc({words[k][31:3], 3'b000});
         apply(words[k], 1'b0);
         chk("R2", "gen crc",   {29'b0, s_crc}, {29'b0, e});
         chk("R2", "gen frame", s_frame, {words[k][31:3], e});
         chk("R8", "gen ok low", {31'b0, s_ok}, 32'd0);
      end
   endtask

   task automatic t_low_bits_ignored;
      logic [31:0] base = 32'hC0DE_F00D & 32'hFFFF_FFF8;
      logic [2:0]  e = ref_crc(base);
      for (int lo = 0; lo < 8; lo++) begin
         apply(base | 32'(lo), 1'b0);
         chk("R4", "crc with low bits set", {29'b0, s_crc}, {29'b0, e});
         chk("R4", "frame with low bits set", s_frame, base | {29'b0, e});
      end
   endtask

   task automatic t_check_words;
      logic [31:0] lf = 32'hACE1_2468;
      for (int n = 0; n < 40; n++) begin
         logic [2:0] e;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         e = ref_crc(lf);
         apply(lf, 1'b1);
         chk("R3", "check remainder", {29'b0, s_crc}, {29'b0, e});
         chk("R3", "check frame passthru", s_frame, lf);
         chk("R3", "check ok", {31'b0, s_ok}, {31'b0, (e == 3'b000)});
      end
   endtask

   task automatic t_roundtrip_and_flips;
      logic [31:0] seeds [4] = '{32'h0, 32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'h0F0F_1234};
      foreach (seeds[k]) begin
         logic [31:0] fr;
         apply(seeds[k], 1'b0);
         fr = s_frame;
         apply(fr, 1'b1);
         chk("R5", "roundtrip remainder", {29'b0, s_crc}, 32'd0);
         chk("R5", "roundtrip ok", {31'b0, s_ok}, 32'd1);
         for (int b = 0; b < 32; b++) begin
            logic [31:0] bad = fr ^ (32'd1 << b);
            apply(bad, 1'b1);
            chk("R6", "flipped bit ok", {31'b0, s_ok}, 32'd0);
            chk("R6", "flipped bit remainder", {29'b0, s_crc}, {29'b0, ref_crc(bad)});
         end
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_seed();
      t_generate();
      t_low_bits_ignored();
      t_check_words();
      t_roundtrip_and_flips();
      finish_run();
   end
endmodule